// File: doc/BRIEF.md
# Interrupt Source Gating and Routing

This block holds the configuration of a parameterised set of interrupt sources. It decides when each source is presented to a single destination processor. Every source has a word-wide vector/priority register and a destination bitmask register. The block synchronises the raw request lines and keeps a pending state for each source, following either the level or the rising edge of the line. It presents a source only when the source's configuration, its activity state and the processor's current task priority all allow it.

A presented source appears in the raised set, which is a one-hot-per-source output vector, and `irq_out` is the OR of that set. At the same time the source's activity bit is set, and that bit blocks a second delivery. The processor side names a source on the acknowledge port to take it out of the raised set. For an edge source the acknowledge also ends its activity. A level source stays active until its line drops. Software reaches the registers through one word-wide read/write port indexed by source number, and reads return the stored word combinationally.

Top module: `irq_src_router`

## Requirements
- R1: After reset every vector/priority register reads 0xA0000000, so every source starts masked. Every destination register reads 0, and the raised set and `irq_out` are 0.
- R2: Vector/priority word layout: bit 31 mask (1 = masked), bit 30 activity (read-only), bit 22 sense (1 = level, 0 = edge), bits 19:16 priority, bits 7:0 vector. Other bits are stored as written. A write never changes bit 30; it reads back the block's own activity state.
- R3: A destination register write (`reg_sel` = 1) keeps bits 31:30 and bits NUM_CPU-1:0 and stores zero in every other bit. Bit 0 is the modelled destination.
- R4: A source is never delivered while any of these holds: it is masked, its priority is zero, its activity bit is set, its destination register is zero, or its destination bit 0 is clear.
- R5: A source is delivered only if its priority is strictly greater than `task_prio`. A source held back only by priority is delivered once `task_prio` drops below its priority, with no new input event.
- R6: On delivery the source's raised bit and activity bit are both set. A raised bit stays set until that source is acknowledged (`ack_en` with `ack_idx`), and a source already in the raised set is not delivered again. `irq_out` is 1 whenever the raised set is non-zero.
- R7: For a level source, pending follows the synchronised line. A low line clears the activity bit. After an acknowledge with the line still high, the source is not delivered again until the line has dropped and risen.
- R8: For an edge source, a rising edge of the synchronised line sets pending, which is held until the source is delivered. An acknowledge clears its activity bit. A line that stays high delivers only once.
- R9: A change on `irq_in` shows in the raised set at the fourth rising clock edge after it is applied. A register write that makes a pending source deliverable shows in the raised set at the second rising edge after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Raw asynchronous interrupt request lines |
| task_prio | input | 4 | Current task priority of the destination processor |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 vector/priority, 1 destination |
| reg_idx | input | $clog2(NUM_SRC) | Source number for the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| ack_en | input | 1 | Acknowledge strobe |
| ack_idx | input | $clog2(NUM_SRC) | Source being acknowledged |
| raised | output | NUM_SRC | Raised set of the destination |
| irq_out | output | 1 | Interrupt request to the destination processor |

## Verification
Input-line results are due at the fourth rising edge after the change: two synchroniser flops, then the pending flop, then the raised flop. Register and task-priority results are due one edge after the write lands. The vector walk waits five cycles after each stimulus before it compares the raised set, so every vector is checked after it has settled. Directed tests then sample at negedges at the exact cycle counts: the raised bit must be clear at the third negedge after an input change and set at the fourth, and clear one negedge after an unmasking write and set at the next. Register reads are compared in the same cycle because the read path has no register.

// File: rtl/irq_router_pkg.sv
// Shared field positions, reset values and helpers for the interrupt router.
// Assumes a 32-bit register word and a 4-bit priority field.
package irq_router_pkg;
    localparam int WORD_W       = 32;
    localparam int PRIO_W       = 4;
    localparam int VP_MASK_BIT  = 31;
    localparam int VP_ACT_BIT   = 30;
    localparam int VP_SENSE_BIT = 22;
    localparam int VP_PRIO_LSB  = 16;
    localparam logic [WORD_W-1:0] VP_RESET_VAL  = 32'hA000_0000;
    localparam logic [WORD_W-1:0] DST_RESET_VAL = 32'h0000_0000;

    typedef enum logic {
        SEL_VECPRI = 1'b0,
        SEL_DEST   = 1'b1
    } reg_sel_e;

    // Bits of a destination word that are kept on a write.
    function automatic logic [WORD_W-1:0] dst_keep_mask(input int ncpu);
        logic [WORD_W-1:0] m;
        m = 32'hC000_0000;
        for (int b = 0; b < ncpu; b++) m[b] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/irq_in_sync.sv
// Two-flop synchroniser with rising-edge detection for a bus of request lines.
// Assumes each raw line is held long enough to be seen by two flops.
module irq_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    // Synchronise the raw lines and remember the previous synchronised value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Present the level and a one-cycle rising-edge pulse.
    always_comb begin
        level = sync_q;
        rise  = sync_q & ~prev_q;
    end
endmodule

// File: rtl/irq_src_slot.sv
// One interrupt source: configuration registers, pending and activity state,
// and the delivery gate towards destination 0.
// Assumes the caller decodes the write strobe and the acknowledge for this slot.
module irq_src_slot
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              line_level,
    input  logic              line_rise,
    input  logic [PRIO_W-1:0] task_prio,
    input  logic              in_raised,
    input  logic              ack_hit,
    output logic [WORD_W-1:0] vp_word,
    output logic [WORD_W-1:0] dst_word,
    output logic              active,
    output logic              deliver
);
    localparam logic [WORD_W-1:0] KEEP = dst_keep_mask(NUM_CPU);

    logic [WORD_W-1:0] vp_q;
    logic [WORD_W-1:0] dst_q;
    logic              pend_q;
    logic              act_q;
    logic              is_level;
    logic              masked;
    logic [PRIO_W-1:0] prio;

    // Decode configuration fields of the stored word.
    always_comb begin
        is_level = vp_q[VP_SENSE_BIT];
        masked   = vp_q[VP_MASK_BIT];
        prio     = vp_q[VP_PRIO_LSB +: PRIO_W];
    end

    // Delivery gate: every condition must allow the source.
    always_comb begin
        deliver = pend_q && !masked && (prio != '0) && !act_q
                  && (dst_q != '0) && dst_q[0] && (prio > task_prio)
                  && !in_raised;
    end

    // Configuration registers; the activity bit position is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vp_q  <= VP_RESET_VAL;
            dst_q <= DST_RESET_VAL;
        end else if (wr_en) begin
            if (wr_sel == SEL_DEST) dst_q <= wdata & KEEP;
            else                    vp_q  <= wdata & ~(32'h1 << VP_ACT_BIT);
        end
    end

    // Pending: follows the level, or is set by an edge and held until delivered.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (is_level)   pend_q <= line_level;
        else if (line_rise)  pend_q <= 1'b1;
        else if (deliver)    pend_q <= 1'b0;
    end

    // Activity: set on delivery, ended by a low level or an edge acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                      act_q <= 1'b0;
        else if (deliver)                act_q <= 1'b1;
        else if (is_level && !line_level) act_q <= 1'b0;
        else if (!is_level && ack_hit)   act_q <= 1'b0;
    end

    // Present the readable words with the live activity bit inserted.
    always_comb begin
        vp_word             = vp_q;
        vp_word[VP_ACT_BIT] = act_q;
        dst_word            = dst_q;
        active              = act_q;
    end
endmodule

// File: rtl/irq_raised_set.sv
// Raised set of the single modelled destination.
// Assumes a delivering source is never the one being acknowledged.
module irq_raised_set #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] deliver,
    input  logic               ack_en,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic [NUM_SRC-1:0] raised
);
    logic [NUM_SRC-1:0] ack_vec;

    // One-hot form of the acknowledge.
    always_comb begin
        ack_vec = '0;
        if (ack_en) ack_vec[ack_idx] = 1'b1;
    end

    // Remove acknowledged sources, add delivered ones.
    always_ff @(posedge clk) begin
        if (!rst_n) raised <= '0;
        else        raised <= (raised & ~ack_vec) | deliver;
    end
endmodule

// File: rtl/irq_src_router.sv
// Top: per-source configuration and gating, routing to one destination.
// Assumes a single destination processor (bit 0 of each destination word).
module irq_src_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_CPU = 2,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [3:0]         task_prio,
    input  logic               reg_wr_en,
    input  logic               reg_sel,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               ack_en,
    input  logic [IDX_W-1:0]   ack_idx,
    output logic [NUM_SRC-1:0] raised,
    output logic               irq_out
);
    logic [NUM_SRC-1:0]             line_level;
    logic [NUM_SRC-1:0]             line_rise;
    logic [NUM_SRC-1:0]             deliver;
    logic [NUM_SRC-1:0]             act_all;
    logic [NUM_SRC-1:0][WORD_W-1:0] vp_all;
    logic [NUM_SRC-1:0][WORD_W-1:0] dst_all;

    irq_in_sync #(.WIDTH(NUM_SRC)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (irq_in),
        .level (line_level),
        .rise  (line_rise)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        irq_src_slot #(.NUM_CPU(NUM_CPU)) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (reg_wr_en && (reg_idx == IDX_W'(i))),
            .wr_sel     (reg_sel),
            .wdata      (reg_wdata),
            .line_level (line_level[i]),
            .line_rise  (line_rise[i]),
            .task_prio  (task_prio),
            .in_raised  (raised[i]),
            .ack_hit    (ack_en && (ack_idx == IDX_W'(i))),
            .vp_word    (vp_all[i]),
            .dst_word   (dst_all[i]),
            .active     (act_all[i]),
            .deliver    (deliver[i])
        );
    end

    irq_raised_set #(.NUM_SRC(NUM_SRC)) rset_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .deliver (deliver),
        .ack_en  (ack_en),
        .ack_idx (ack_idx),
        .raised  (raised)
    );

    // Combinational register read and request output.
    always_comb begin
        reg_rdata = (reg_sel == SEL_DEST) ? dst_all[reg_idx] : vp_all[reg_idx];
        irq_out   = |raised;
    end
endmodule

// File: rtl/irq_src_router_chk.sv
// Property checker for the interrupt router, attached by bind.
module irq_src_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_CPU = 2,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [3:0]                       task_prio,
    input logic                             ack_en,
    input logic [IDX_W-1:0]                 ack_idx,
    input logic [NUM_SRC-1:0]               raised,
    input logic [NUM_SRC-1:0]               act_all,
    input logic [NUM_SRC-1:0][WORD_W-1:0]   vp_all,
    input logic [NUM_SRC-1:0][WORD_W-1:0]   dst_all
);
    localparam logic [WORD_W-1:0] KEEP = dst_keep_mask(NUM_CPU);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        AST_RAISE_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raised[i]) |-> !$past(vp_all[i][VP_MASK_BIT]));  // R4
        AST_RAISE_NEEDS_DEST0: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raised[i]) |-> $past(dst_all[i][0]));  // R4
        AST_RAISE_ABOVE_TASK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raised[i]) |-> ($past(vp_all[i][VP_PRIO_LSB +: PRIO_W]) > $past(task_prio)));  // R5
        AST_RAISE_SETS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(raised[i]) |-> (act_all[i] && !$past(act_all[i])));  // R6
        AST_RAISED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (raised[i] && !(ack_en && ack_idx == IDX_W'(i))) |=> raised[i]);  // R6
        AST_DST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (dst_all[i] & ~KEEP) == '0);  // R3
    end
endmodule

bind irq_src_router irq_src_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .task_prio (task_prio),
    .ack_en    (ack_en),
    .ack_idx   (ack_idx),
    .raised    (raised),
    .act_all   (act_all),
    .vp_all    (vp_all),
    .dst_all   (dst_all)
);

// File: tb/irq_src_router_tb.sv
// Self-checking bench: a vector table walk, then directed tests.
module irq_src_router_tb_top;
    localparam int NS = 8;
    localparam logic [2:0] OP_WVP = 3'd0, OP_WDST = 3'd1, OP_IRQ = 3'd2,
                           OP_ACK = 3'd3, OP_TASK = 3'd4;
    localparam int NVEC = 33;
    // Entry: op, source, data, expected raised set after settling.
    localparam logic [45:0] TBL [NVEC] = '{
        {OP_WDST, 3'd0, 32'h0000_0001, 8'h00},
        {OP_WVP,  3'd0, 32'h0005_0011, 8'h00},
        {OP_IRQ,  3'd0, 32'h0000_0001, 8'h01},
        {OP_ACK,  3'd0, 32'h0000_0000, 8'h00},
        {OP_IRQ,  3'd0, 32'h0000_0000, 8'h00},
        {OP_IRQ,  3'd0, 32'h0000_0001, 8'h01},
        {OP_ACK,  3'd0, 32'h0000_0000, 8'h00},
        {OP_WDST, 3'd1, 32'h0000_0001, 8'h00},
        {OP_WVP,  3'd1, 32'h0043_0022, 8'h00},
        {OP_IRQ,  3'd0, 32'h0000_0003, 8'h02},
        {OP_ACK,  3'd1, 32'h0000_0000, 8'h00},
        {OP_IRQ,  3'd0, 32'h0000_0001, 8'h00},
        {OP_IRQ,  3'd0, 32'h0000_0003, 8'h02},
        {OP_TASK, 3'd0, 32'h0000_0003, 8'h02},
        {OP_ACK,  3'd1, 32'h0000_0000, 8'h00},
        {OP_IRQ,  3'd0, 32'h0000_0001, 8'h00},
        {OP_IRQ,  3'd0, 32'h0000_0003, 8'h00},
        {OP_TASK, 3'd0, 32'h0000_0002, 8'h02},
        {OP_ACK,  3'd1, 32'h0000_0000, 8'h00},
        {OP_IRQ,  3'd0, 32'h0000_0001, 8'h00},
        {OP_WDST, 3'd2, 32'h0000_0001, 8'h00},
        {OP_WVP,  3'd2, 32'h8007_0033, 8'h00},
        {OP_IRQ,  3'd0, 32'h0000_0005, 8'h00},
        {OP_WVP,  3'd2, 32'h0007_0033, 8'h04},
        {OP_ACK,  3'd2, 32'h0000_0000, 8'h00},
        {OP_WDST, 3'd3, 32'h0000_0001, 8'h00},
        {OP_WVP,  3'd3, 32'h0040_0044, 8'h00},
        {OP_IRQ,  3'd0, 32'h0000_000D, 8'h00},
        {OP_WVP,  3'd4, 32'h0006_0055, 8'h00},
        {OP_IRQ,  3'd0, 32'h0000_001D, 8'h00},
        {OP_WDST, 3'd4, 32'h0000_0002, 8'h00},
        {OP_WDST, 3'd4, 32'h0000_0001, 8'h10},
        {OP_ACK,  3'd4, 32'h0000_0000, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_in = '0;
    logic [3:0]    task_prio = '0;
    logic          reg_wr_en = 1'b0;
    logic          reg_sel = 1'b0;
    logic [2:0]    reg_idx = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          ack_en = 1'b0;
    logic [2:0]    ack_idx = '0;
    logic [NS-1:0] raised;
    logic          irq_out;
    int            n_chk = 0;
    int            n_bad = 0;

    always #5 clk = ~clk;

    irq_src_router dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .task_prio(task_prio),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_en(ack_en),
        .ack_idx(ack_idx), .raised(raised), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic sel, input logic [2:0] idx, input logic [31:0] exp);
        reg_sel = sel; reg_idx = idx;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic ack(input logic [2:0] idx);
        @(negedge clk);
        ack_en = 1'b1; ack_idx = idx;
        @(negedge clk);
        ack_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset contents of every register and output
        for (int i = 0; i < NS; i++) begin
            rd("R1 reset vecpri", 1'b0, 3'(i), 32'hA000_0000);
            rd("R1 reset dest", 1'b1, 3'(i), 32'h0);
        end
        check("R1 reset raised", {24'h0, raised}, 32'h0);
        check("R1 reset irq_out", {31'h0, irq_out}, 32'h0);

        // Table walk: R4 R5 R6 R7 R8 gating, strict priority, level and edge semantics
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0]  op;
            logic [2:0]  idx;
            logic [31:0] d;
            logic [7:0]  e;
            {op, idx, d, e} = TBL[v];
            case (op)
                OP_WVP:  wr(1'b0, idx, d);
                OP_WDST: wr(1'b1, idx, d);
                OP_IRQ:  begin @(negedge clk); irq_in = d[NS-1:0]; end
                OP_ACK:  ack(idx);
                default: begin @(negedge clk); task_prio = d[3:0]; end
            endcase
            repeat (5) @(negedge clk);
            check($sformatf("R4 R5 R6 R7 R8 vector %0d raised", v), {24'h0, raised}, {24'h0, e});
            check($sformatf("R6 vector %0d irq_out", v), {31'h0, irq_out}, {31'h0, |e});
        end

        // R9: input change reaches the raised set at the fourth edge
        wr(1'b1, 3'd6, 32'h1);
        wr(1'b0, 3'd6, 32'h0009_0077);
        @(negedge clk); irq_in = 8'h5D;
        repeat (3) @(negedge clk);
        check("R9 input latency early", {31'h0, raised[6]}, 32'h0);
        @(negedge clk);
        check("R9 input latency due", {31'h0, raised[6]}, 32'h1);
        ack(3'd6);
        repeat (2) @(negedge clk);
        // R2: software cannot set the activity bit
        wr(1'b0, 3'd6, 32'h4009_0077);
        rd("R2 activity not writable", 1'b0, 3'd6, 32'h0009_0077);

        // R9: unmasking a pending source raises it one edge after the write lands
        wr(1'b1, 3'd7, 32'h1);
        wr(1'b0, 3'd7, 32'h8008_0088);
        @(negedge clk); irq_in = 8'hDD;
        repeat (5) @(negedge clk);
        check("R4 masked pending held", {31'h0, raised[7]}, 32'h0);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = 1'b0; reg_idx = 3'd7; reg_wdata = 32'h0008_0088;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check("R9 write latency early", {31'h0, raised[7]}, 32'h0);
        @(negedge clk);
        check("R9 write latency due", {31'h0, raised[7]}, 32'h1);

        // R2: activity bit preserved across writes while active
        rd("R2 activity visible", 1'b0, 3'd7, 32'h4008_0088);
        wr(1'b0, 3'd7, 32'h0008_0088);
        rd("R2 activity kept on write", 1'b0, 3'd7, 32'h4008_0088);
        wr(1'b0, 3'd7, 32'h8008_0088);
        rd("R2 activity kept with mask", 1'b0, 3'd7, 32'hC008_0088);
        check("R6 raised held until ack", {24'h0, raised}, 32'h80);
        check("R6 irq_out with raised", {31'h0, irq_out}, 32'h1);
        ack(3'd7);
        rd("R8 edge ack clears activity", 1'b0, 3'd7, 32'h8008_0088);
        check("R6 ack clears raised", {24'h0, raised}, 32'h0);

        // R3: destination register keeps only the top two bits and processor bits
        wr(1'b1, 3'd5, 32'hFFFF_FFFF);
        rd("R3 dest write mask", 1'b1, 3'd5, 32'hC000_0003);
        wr(1'b1, 3'd5, 32'h3FFF_FFFC);
        rd("R3 dest reserved zero", 1'b1, 3'd5, 32'h0);

        // R1: reset again returns registers and outputs to their initial state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd("R1 re-reset vecpri", 1'b0, 3'd7, 32'hA000_0000);
        rd("R1 re-reset dest", 1'b1, 3'd0, 32'h0);
        check("R1 re-reset raised", {24'h0, raised}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule